// File: doc/BRIEF.md
# Cache-Line Instruction Extractor

This block sits between the instruction cache and decode in a fetch stage. When a request arrives it takes a 64-byte line and the current fetch PC. It then emits up to `FETCH_W` consecutive 32-bit instructions in one group. Each emitted slot carries its PC, a sequence number drawn from a global counter, and a predicted next PC.

Two inputs per line word mark control and quiesce instructions, and they come from a small opcode predicate outside the block. A branch predictor, also outside the block, supplies a taken flag and a target for every word. A group ends at whichever comes first:
- the end of the line;
- the fetch width;
- a predicted-taken control instruction;
- a quiesce instruction.

When the request reports a translation fault, the block emits a single placeholder no-op carrying the fault code instead of reading the line. The thread then moves to a trap-pending state.

All results are registered and appear exactly one cycle after the request. The updated thread PC and next PC come out with them.

Top module: `fetch_line_extract`

## Requirements
- R1: After reset `out_valid_o` is 0, `out_count_o` is 0, `status_o` is 0 (running), and the first emitted sequence number is 0.
- R2: `line_addr_o` equals the request PC with its low 6 bits cleared.
- R3: Slot 0 holds line word `pc[5:2]`. Later slots hold the following words. Word w sits at `line_data_i[32*w+31:32*w]`, and per-word flag or target w sits at bit w or field w.
- R4: `out_count_o` never exceeds `FETCH_W`. Extraction stops after word 15 of the line, so the count is at most `16 - pc[5:2]` when nothing else ends the group.
- R5: For a slot that is not a predicted-taken control instruction, the predicted next PC is the slot PC plus 4, and the next slot's PC is that value. A taken flag on a non-control word has no effect.
- R6: A control word with its taken flag set is emitted as the last slot of the group. Its predicted next PC is that word's predictor target.
- R7: A quiesce word is emitted and counted, the group ends after it, and `status_o` becomes 1 (quiesce pending).
- R8: Slot i carries sequence number base+i, and the base advances by the number of slots emitted, across groups.
- R9: `pc_o` is the predicted next PC of the last emitted slot, and `npc_o` is `pc_o + 4`.
- R10: With `fault_i` set, exactly one slot is emitted. It holds instruction 0x00000013 at the request PC, takes one sequence number, and raises `fault_o` with `fault_code_o` equal to the input code. In this case `status_o` is 2 (trap pending) and `pc_o` is the request PC.
- R11: Outputs are valid for exactly one cycle, the cycle after `req_valid_i`. A cycle without a request emits nothing and consumes no sequence numbers.
- R12: Valid slots are contiguous from slot 0, and `out_count_o` equals the number of set bits in `slot_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Line and PC present this cycle |
| req_pc_i | input | ADDR_W | Fetch PC of the thread |
| line_data_i | input | 512 | Cache line, word w at bits 32w+31:32w |
| is_ctrl_i | input | 16 | Per-word control-instruction flag |
| is_quiesce_i | input | 16 | Per-word quiesce flag |
| pred_taken_i | input | 16 | Per-word predictor taken flag |
| pred_target_i | input | 16*ADDR_W | Per-word predictor target |
| fault_i | input | 1 | Translation fault for this request |
| fault_code_i | input | FAULT_W | Fault code |
| out_valid_o | output | 1 | Group valid |
| line_addr_o | output | ADDR_W | Line-aligned request address |
| slot_valid_o | output | FETCH_W | Per-slot valid |
| slot_inst_o | output | FETCH_W*32 | Slot instructions |
| slot_pc_o | output | FETCH_W*ADDR_W | Slot PCs |
| slot_seq_o | output | FETCH_W*SEQ_W | Slot sequence numbers |
| slot_npc_o | output | FETCH_W*ADDR_W | Slot predicted next PCs |
| out_count_o | output | CNT_W | Slots emitted |
| pc_o | output | ADDR_W | Updated thread PC |
| npc_o | output | ADDR_W | Updated thread next PC |
| status_o | output | 2 | 0 running, 1 quiesce pending, 2 trap pending |
| fault_o | output | 1 | Group is a fault placeholder |
| fault_code_o | output | FAULT_W | Carried fault code |

## Verification
The table applies straight-line requests at line start, near the line end and on the last word. This separates the width limit from the line-end limit. Branch patterns follow: a taken branch in the middle of a group and in the first slot, a control word predicted not taken, and a taken flag on a non-control word. Together they show that only control words with a taken prediction redirect the group. A mid-group quiesce shows that the word is still counted and that the status changes. Directed runs then cover the fault placeholder, idle cycles, and the sequence numbers flowing across groups.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_QUIESCE = 2'd1,
    ST_TRAP    = 2'd2
  } fx_status_e;
endpackage

// File: rtl/fx_slot.sv
// One extraction position: picks its line word and resolves its next PC.
module fx_slot #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 16,
  parameter int INST_BYTES = 4,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                    alive_i,
  input  logic [WIDX_W:0]         widx_i,
  input  logic [ADDR_W-1:0]       pc_i,
  input  logic [WORDS*32-1:0]     line_i,
  input  logic [WORDS-1:0]        ctrl_i,
  input  logic [WORDS-1:0]        quies_i,
  input  logic [WORDS-1:0]        taken_i,
  input  logic [WORDS*ADDR_W-1:0] target_i,
  output logic                    valid_o,
  output logic [31:0]             inst_o,
  output logic [ADDR_W-1:0]       npc_o,
  output logic                    alive_o,
  output logic                    quiesce_o
);
  logic [WIDX_W-1:0] sel;
  logic in_line, redirect;

  assign sel      = widx_i[WIDX_W-1:0];
  assign in_line  = (widx_i[WIDX_W] == 1'b0);
  assign valid_o  = alive_i && in_line;
  assign inst_o   = line_i[32*int'(sel) +: 32];
  assign redirect = ctrl_i[sel] && taken_i[sel];
  assign npc_o    = redirect ? target_i[ADDR_W*int'(sel) +: ADDR_W]
                             : pc_i + ADDR_W'(INST_BYTES);
  assign quiesce_o = valid_o && quies_i[sel];
  assign alive_o   = valid_o && !redirect && !quies_i[sel];
endmodule

// File: rtl/fx_seq_ctr.sv
// Global sequence-number source.
module fx_seq_ctr #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [SEQ_W-1:0] base_o
);
  always_ff @(posedge clk) begin
    if (rst)        base_o <= '0;
    else if (adv_i) base_o <= base_o + SEQ_W'(inc_i);
  end
endmodule

// File: rtl/fetch_line_extract.sv
module fetch_line_extract #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int INST_BYTES = 4,
  parameter int FETCH_W    = 4,
  parameter int SEQ_W      = 16,
  parameter int FAULT_W    = 4,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013,
  localparam int WORDS  = LINE_BYTES / INST_BYTES,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IB_W   = $clog2(INST_BYTES),
  localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_pc_i,
  input  logic [WORDS*32-1:0]       line_data_i,
  input  logic [WORDS-1:0]          is_ctrl_i,
  input  logic [WORDS-1:0]          is_quiesce_i,
  input  logic [WORDS-1:0]          pred_taken_i,
  input  logic [WORDS*ADDR_W-1:0]   pred_target_i,
  input  logic                      fault_i,
  input  logic [FAULT_W-1:0]        fault_code_i,
  output logic                      out_valid_o,
  output logic [ADDR_W-1:0]         line_addr_o,
  output logic [FETCH_W-1:0]        slot_valid_o,
  output logic [FETCH_W*32-1:0]     slot_inst_o,
  output logic [FETCH_W*ADDR_W-1:0] slot_pc_o,
  output logic [FETCH_W*SEQ_W-1:0]  slot_seq_o,
  output logic [FETCH_W*ADDR_W-1:0] slot_npc_o,
  output logic [CNT_W-1:0]          out_count_o,
  output logic [ADDR_W-1:0]         pc_o,
  output logic [ADDR_W-1:0]         npc_o,
  output logic [1:0]                status_o,
  output logic                      fault_o,
  output logic [FAULT_W-1:0]        fault_code_o
);
  import fx_pkg::*;

  logic [WIDX_W:0]    start_w;
  logic               alive [FETCH_W+1];
  logic [ADDR_W-1:0]  pc_ch [FETCH_W+1];
  logic [FETCH_W-1:0] v_n, q_hit;
  logic [31:0]        inst_w [FETCH_W];
  logic [ADDR_W-1:0]  npc_w  [FETCH_W];
  logic [SEQ_W-1:0]   seq_base;

  logic [FETCH_W-1:0]        v_d;
  logic [FETCH_W*32-1:0]     inst_d;
  logic [FETCH_W*ADDR_W-1:0] pc_d, npc_d;
  logic [FETCH_W*SEQ_W-1:0]  seq_d;
  logic [CNT_W-1:0]          cnt_d;
  logic [ADDR_W-1:0]         tpc_d;
  fx_status_e                st_d;

  assign start_w  = {1'b0, req_pc_i[OFF_W-1:IB_W]};
  assign alive[0] = req_valid_i && !fault_i;
  assign pc_ch[0] = req_pc_i;

  for (genvar i = 0; i < FETCH_W; i++) begin : g_slot
    fx_slot #(.ADDR_W(ADDR_W), .WORDS(WORDS), .INST_BYTES(INST_BYTES)) u_slot (
      .alive_i  (alive[i]),
      .widx_i   (start_w + (WIDX_W+1)'(i)),
      .pc_i     (pc_ch[i]),
      .line_i   (line_data_i),
      .ctrl_i   (is_ctrl_i),
      .quies_i  (is_quiesce_i),
      .taken_i  (pred_taken_i),
      .target_i (pred_target_i),
      .valid_o  (v_n[i]),
      .inst_o   (inst_w[i]),
      .npc_o    (npc_w[i]),
      .alive_o  (alive[i+1]),
      .quiesce_o(q_hit[i])
    );
    assign pc_ch[i+1] = v_n[i] ? npc_w[i] : pc_ch[i];
  end

  fx_seq_ctr #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .adv_i (req_valid_i),
    .inc_i (cnt_d),
    .base_o(seq_base)
  );

  always_comb begin
    v_d   = v_n;
    cnt_d = '0;
    tpc_d = pc_ch[FETCH_W];
    st_d  = (|q_hit) ? ST_QUIESCE : ST_RUN;
    for (int i = 0; i < FETCH_W; i++) begin
      inst_d[32*i +: 32]         = inst_w[i];
      pc_d[ADDR_W*i +: ADDR_W]   = pc_ch[i];
      npc_d[ADDR_W*i +: ADDR_W]  = npc_w[i];
      seq_d[SEQ_W*i +: SEQ_W]    = seq_base + SEQ_W'(i);
      cnt_d = cnt_d + CNT_W'(v_n[i]);
    end
    if (fault_i) begin
      v_d            = '0;
      v_d[0]         = 1'b1;
      inst_d[31:0]   = NOP_WORD;
      npc_d[ADDR_W-1:0] = req_pc_i + ADDR_W'(INST_BYTES);
      cnt_d          = CNT_W'(1);
      tpc_d          = req_pc_i;
      st_d           = ST_TRAP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o  <= 1'b0;
      line_addr_o  <= '0;
      slot_valid_o <= '0;
      slot_inst_o  <= '0;
      slot_pc_o    <= '0;
      slot_seq_o   <= '0;
      slot_npc_o   <= '0;
      out_count_o  <= '0;
      pc_o         <= '0;
      npc_o        <= '0;
      status_o     <= ST_RUN;
      fault_o      <= 1'b0;
      fault_code_o <= '0;
    end else begin
      out_valid_o <= req_valid_i;
      if (req_valid_i) begin
        line_addr_o  <= {req_pc_i[ADDR_W-1:OFF_W], OFF_W'(0)};
        slot_valid_o <= v_d;
        slot_inst_o  <= inst_d;
        slot_pc_o    <= pc_d;
        slot_seq_o   <= seq_d;
        slot_npc_o   <= npc_d;
        out_count_o  <= cnt_d;
        pc_o         <= tpc_d;
        npc_o        <= tpc_d + ADDR_W'(INST_BYTES);
        status_o     <= st_d;
        fault_o      <= fault_i;
        fault_code_o <= fault_i ? fault_code_i : '0;
      end
    end
  end
endmodule

// File: rtl/fx_chk.sv
module fx_chk #(
  parameter int ADDR_W  = 32,
  parameter int FETCH_W = 4,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid_i,
  input logic               out_valid_o,
  input logic [FETCH_W-1:0] slot_valid_o,
  input logic [SEQ_W-1:0]   seq0,
  input logic [CNT_W-1:0]   out_count_o,
  input logic [ADDR_W-1:0]  pc_o,
  input logic [ADDR_W-1:0]  npc_o,
  input logic [1:0]         status_o,
  input logic               fault_o
);
  logic [SEQ_W-1:0]   exp_seq;
  logic [FETCH_W-1:0] sv_inc;

  assign sv_inc = slot_valid_o + FETCH_W'(1);

  always_ff @(posedge clk) begin
    if (rst)              exp_seq <= '0;
    else if (out_valid_o) exp_seq <= exp_seq + SEQ_W'(out_count_o);
  end

  // R11
  req_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> out_valid_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !out_valid_o);
  // R12
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> ($countones(slot_valid_o) == int'(out_count_o)));
  // R12
  contig_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> ((slot_valid_o & sv_inc) == '0));
  // R4
  cap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (int'(out_count_o) <= FETCH_W && out_count_o != '0));
  // R8
  seq_chain_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (seq0 == exp_seq));
  // R9
  npc_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (npc_o == pc_o + ADDR_W'(4)));
  // R10
  fault_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && fault_o) |-> (out_count_o == CNT_W'(1) && status_o == 2'd2));
endmodule

bind fetch_line_extract fx_chk #(
  .ADDR_W(ADDR_W), .FETCH_W(FETCH_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .out_valid_o(out_valid_o),
  .slot_valid_o(slot_valid_o), .seq0(slot_seq_o[SEQ_W-1:0]),
  .out_count_o(out_count_o), .pc_o(pc_o), .npc_o(npc_o),
  .status_o(status_o), .fault_o(fault_o)
);

// File: tb/fetch_line_extract_tb.sv
`timescale 1ns/1ps
module fetch_line_extract_tb;
  localparam int AW = 32, FW = 4, SW = 16, FCW = 4, NW = 16, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, fault = 1'b0;
  logic [AW-1:0] req_pc = '0;
  logic [NW*32-1:0] line;
  logic [NW-1:0] ctrl = '0, quies = '0, taken = '0;
  logic [NW*AW-1:0] targets;
  logic [FCW-1:0] fcode = '0;

  logic out_valid, fault_out;
  logic [AW-1:0] line_addr, pc_out, npc_out;
  logic [FW-1:0] slot_valid;
  logic [FW*32-1:0] slot_inst;
  logic [FW*AW-1:0] slot_pc, slot_npc;
  logic [FW*SW-1:0] slot_seq;
  logic [CW-1:0] count;
  logic [1:0] status;
  logic [FCW-1:0] fcode_out;

  int n_chk = 0, n_fail = 0;
  logic [SW-1:0] exp_seq = '0;

  always #2 clk = ~clk;

  fetch_line_extract u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_pc_i(req_pc),
    .line_data_i(line), .is_ctrl_i(ctrl), .is_quiesce_i(quies),
    .pred_taken_i(taken), .pred_target_i(targets), .fault_i(fault),
    .fault_code_i(fcode), .out_valid_o(out_valid), .line_addr_o(line_addr),
    .slot_valid_o(slot_valid), .slot_inst_o(slot_inst), .slot_pc_o(slot_pc),
    .slot_seq_o(slot_seq), .slot_npc_o(slot_npc), .out_count_o(count),
    .pc_o(pc_out), .npc_o(npc_out), .status_o(status), .fault_o(fault_out),
    .fault_code_o(fcode_out));

  typedef struct packed {
    logic [31:0] pc;
    logic [15:0] c, t, q;
    logic [3:0]  cnt;
    logic [31:0] pco;
    logic [1:0]  st;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 16'h0, 16'h0, 16'h0, 4'd4, 32'h1010, 2'd0},         // width limit
    '{32'h1034, 16'h0, 16'h0, 16'h0, 4'd3, 32'h1040, 2'd0},         // line end
    '{32'h103C, 16'h0, 16'h0, 16'h0, 4'd1, 32'h1040, 2'd0},         // last word
    '{32'h1000, 16'h2, 16'h2, 16'h0, 4'd2, 32'h8000_0100, 2'd0},    // taken mid
    '{32'h1000, 16'h2, 16'h0, 16'h0, 4'd4, 32'h1010, 2'd0},         // not taken
    '{32'h1000, 16'h0, 16'h2, 16'h0, 4'd4, 32'h1010, 2'd0},         // taken ignored
    '{32'h1008, 16'h0, 16'h0, 16'h8, 4'd2, 32'h1010, 2'd1},         // quiesce
    '{32'h1004, 16'h2, 16'h2, 16'h0, 4'd1, 32'h8000_0100, 2'd0},    // taken first
    '{32'h1030, 16'h0, 16'h0, 16'h0, 4'd4, 32'h1040, 2'd0}          // exact fit
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] pc, input logic [15:0] c, t, q, input logic f, input logic [3:0] code);
    @(negedge clk);
    req_pc = pc; ctrl = c; taken = t; quies = q; fault = f; fcode = code;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; fault = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      line[32*w +: 32]    = 32'hA000_0000 + w;
      targets[AW*w +: AW] = 32'h8000_0000 + w * 256;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 0);
    chk(count == '0, "R1 count", 64'(count), 0);
    chk(status == 2'd0, "R1 status", 64'(status), 0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] w0;
      logic [31:0] e0npc;
      int last;
      issue(VECS[v].pc, VECS[v].c, VECS[v].t, VECS[v].q, 1'b0, 4'h0);
      w0 = VECS[v].pc[5:2];
      e0npc = (VECS[v].c[w0] && VECS[v].t[w0]) ? 32'h8000_0000 + 32'(w0) * 256 : VECS[v].pc + 4;
      last = int'(VECS[v].cnt) - 1;
      chk(out_valid == 1'b1, "R11 valid", 64'(out_valid), 1);
      chk(count == CW'(VECS[v].cnt), "R4 R6 R7 count", 64'(count), 64'(VECS[v].cnt));
      chk(slot_valid == FW'((1 << VECS[v].cnt) - 1), "R12 slot valid", 64'(slot_valid), 64'((1 << VECS[v].cnt) - 1));
      chk(pc_out == VECS[v].pco, "R9 R6 pc", 64'(pc_out), 64'(VECS[v].pco));
      chk(npc_out == VECS[v].pco + 4, "R9 npc", 64'(npc_out), 64'(VECS[v].pco + 4));
      chk(status == VECS[v].st, "R7 status", 64'(status), 64'(VECS[v].st));
      chk(line_addr == (VECS[v].pc & ~32'h3F), "R2 line addr", 64'(line_addr), 64'(VECS[v].pc & ~32'h3F));
      chk(slot_inst[31:0] == 32'hA000_0000 + 32'(w0), "R3 slot0 inst", 64'(slot_inst[31:0]), 64'(32'hA000_0000 + 32'(w0)));
      chk(slot_npc[31:0] == e0npc, "R5 R6 slot0 npc", 64'(slot_npc[31:0]), 64'(e0npc));
      chk(slot_npc[AW*last +: AW] == VECS[v].pco, "R9 last npc", 64'(slot_npc[AW*last +: AW]), 64'(VECS[v].pco));
      chk(slot_seq[SW-1:0] == exp_seq, "R8 seq base", 64'(slot_seq[SW-1:0]), 64'(exp_seq));
      if (VECS[v].cnt > 1) begin
        chk(slot_seq[SW +: SW] == exp_seq + 1, "R8 seq step", 64'(slot_seq[SW +: SW]), 64'(exp_seq + 1));
        chk(slot_pc[AW +: AW] == e0npc, "R5 slot1 pc", 64'(slot_pc[AW +: AW]), 64'(e0npc));
        chk(slot_inst[32 +: 32] == 32'hA000_0001 + 32'(w0), "R3 slot1 inst", 64'(slot_inst[32 +: 32]), 64'(32'hA000_0001 + 32'(w0)));
      end
      exp_seq = exp_seq + SW'(VECS[v].cnt);
    end

    // R10 fault placeholder
    issue(32'h2000, 16'h0, 16'h0, 16'h0, 1'b1, 4'h5);
    chk(count == CW'(1), "R10 count", 64'(count), 1);
    chk(slot_valid == 4'b0001, "R10 slot valid", 64'(slot_valid), 1);
    chk(slot_inst[31:0] == 32'h0000_0013, "R10 nop", 64'(slot_inst[31:0]), 64'h13);
    chk(fault_out == 1'b1 && fcode_out == 4'h5, "R10 fault code", 64'({fault_out, fcode_out}), 64'h15);
    chk(status == 2'd2, "R10 status", 64'(status), 2);
    chk(pc_out == 32'h2000, "R10 pc", 64'(pc_out), 64'h2000);
    chk(slot_seq[SW-1:0] == exp_seq, "R10 seq", 64'(slot_seq[SW-1:0]), 64'(exp_seq));
    exp_seq = exp_seq + 1;

    // R11 idle cycles emit nothing
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle", 64'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle2", 64'(out_valid), 0);

    issue(32'h1000, 16'h0, 16'h0, 16'h0, 1'b0, 4'h0);
    chk(slot_seq[SW-1:0] == exp_seq, "R8 R11 seq after idle", 64'(slot_seq[SW-1:0]), 64'(exp_seq));
    chk(status == 2'd0 && fault_out == 1'b0, "R10 cleared", 64'({status, fault_out}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule